// File: doc/BRIEF.md
# SCL Clock Timing Generator

This block produces the serial clock timing for a two-wire bus controller. A power-of-two prescaler derives a tick enable from the system clock. The low and high halves of each clock period are then counted in those ticks. All three settings come from a 32-bit timing configuration word. The generator drives an SCL level request, which is low during the low phase and released at all other times. It also issues single-cycle strobes at the phase edges and at the middle of each phase, so that a byte engine can shift data on them.

The byte engine starts the clock by asserting `run`. The generator always finishes a low phase and its following high phase before it checks `run` again. Clock stretching is supported: the high-phase count advances only while the sensed SCL line is actually high. Deasserting `enable` stops the generator at once, releases SCL and restarts the prescaler.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while `run` stays low, `scl_level` is 1 and no strobe is asserted.
- R2: The low phase lasts (lo+1)·2^base system cycles. The exponent `base` is taken from bits 3:0 of the timing word and `lo` from bits 15:12.
- R3: With the sensed line high, the high phase lasts (hi+1)·2^base system cycles, where `hi` is taken from bits 19:16.
- R4: A field value of 0 gives a phase of exactly one prescaled tick (2^base cycles).
- R5: Timing-word bits 31:20 and 11:4 have no effect on phase lengths or strobe positions.
- R6: While the generator requests high but `scl_sense` is low, the high count does not advance. Each such cycle lengthens the high phase by one cycle when base is 0.
- R7: `scl_fall_stb` pulses for one cycle in the first cycle of each low phase, and `scl_rise_stb` pulses for one cycle in the first cycle of each high phase.
- R8: `mid_low_stb` pulses ((lo>>1)+1)·2^base cycles after the fall strobe. `mid_high_stb` pulses ((hi>>1)+1)·2^base counted ticks after the rise strobe. When a field is 0, the mid strobe coincides with the next edge strobe.
- R9: If `run` drops during a low phase, that low phase and the following high phase complete, and the generator then idles with SCL released and no further fall strobe.
- R10: With `enable` low, the generator is idle with SCL released one cycle later. The prescaler restarts, so the next low phase has its exact nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Generator enable; low forces idle |
| run | input | 1 | Request from the byte engine to keep clocking |
| timing_cfg | input | 32 | Timing word: base[3:0], lo[15:12], hi[19:16] |
| scl_sense | input | 1 | Sensed level of the SCL line |
| scl_level | output | 1 | Requested SCL level (0 = drive low) |
| scl_rise_stb | output | 1 | First cycle of a high phase |
| scl_fall_stb | output | 1 | First cycle of a low phase |
| mid_high_stb | output | 1 | Middle of the high phase |
| mid_low_stb | output | 1 | Middle of the low phase |

## Verification
The bench measures phase lengths and mid-strobe offsets across several prescaler exponents and field values, including zero and all-ones fields. An off-by-one in the stored-minus-one encoding, or a prescaler that counts the wrong number of cycles, changes these lengths. A stretch case holds the sensed line low for a known number of cycles. A generator that counts through the stretch would produce a high phase that is too short. Other cases toggle the timing bits the block does not use, drop `run` during a low phase, and disable the block partway through a prescaler interval. These catch a decoder reading the wrong bits, a generator that stops mid-period or keeps clocking, and a prescaler that is not restarted.

// File: rtl/scl_timing_pkg.sv
// Shared types for the SCL timing generator.
package scl_timing_pkg;
    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;
endpackage

// File: rtl/scl_cfg_fields.sv
// Extracts the prescaler exponent and the two phase counts from the timing
// word. Assumes fields do not overlap; all other bits are dropped.
module scl_cfg_fields #(
    parameter int CFG_W   = 32,
    parameter int BASE_W  = 4,
    parameter int CNT_W   = 4,
    parameter int BASE_LSB = 0,
    parameter int LO_LSB   = 12,
    parameter int HI_LSB   = 16
) (
    input  logic [CFG_W-1:0]  cfg,
    output logic [BASE_W-1:0] base,
    output logic [CNT_W-1:0]  lo_cnt,
    output logic [CNT_W-1:0]  hi_cnt
);
    // Field slicing; only these bit ranges reach the timing logic.
    always_comb begin
        base   = cfg[BASE_LSB +: BASE_W];
        lo_cnt = cfg[LO_LSB   +: CNT_W];
        hi_cnt = cfg[HI_LSB   +: CNT_W];
    end
endmodule

// File: rtl/scl_prescaler.sv
// Power-of-two prescaler: issues a one-cycle tick every 2^base cycles.
// Assumes base may change only while restarted for exact timing.
module scl_prescaler #(
    parameter int BASE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [BASE_W-1:0] base,
    output logic              tick
);
    localparam int PRE_W = (1 << BASE_W) - 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] wrap_val;

    // Terminal count for the selected exponent.
    always_comb begin
        wrap_val = ~({PRE_W{1'b1}} << base);
        tick     = !restart && (cnt == wrap_val);
    end

    // Cycle counter, cleared on restart and on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // R2: after a tick the next tick is at least two cycles away unless base is 0.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && base != '0) |=> (!tick || base == '0));
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: walks idle -> low -> high -> (low | idle), counting each
// phase in prescaled ticks and emitting edge and mid strobes. Assumes the
// tick input comes from a prescaler held in restart while idle.
module scl_phase_fsm
    import scl_timing_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic             scl_sense,
    output scl_phase_e       phase,
    output logic             scl_level,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             mid_hi_stb,
    output logic             mid_lo_stb
);
    scl_phase_e       phase_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             rise_nxt, fall_nxt, mhi_nxt, mlo_nxt;

    // Next phase, tick count and strobes.
    always_comb begin
        phase_nxt = phase;
        cnt_nxt   = cnt;
        rise_nxt  = 1'b0;
        fall_nxt  = 1'b0;
        mhi_nxt   = 1'b0;
        mlo_nxt   = 1'b0;
        if (!enable) begin
            phase_nxt = PH_IDLE;
            cnt_nxt   = '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (run) begin
                        phase_nxt = PH_LOW;
                        cnt_nxt   = '0;
                        fall_nxt  = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        mlo_nxt = (cnt == (lo_cnt >> 1));
                        if (cnt == lo_cnt) begin
                            phase_nxt = PH_HIGH;
                            cnt_nxt   = '0;
                            rise_nxt  = 1'b1;
                        end else begin
                            cnt_nxt = cnt + 1'b1;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick && scl_sense) begin
                        mhi_nxt = (cnt == (hi_cnt >> 1));
                        cnt_nxt = cnt + 1'b1;
                        if (cnt == hi_cnt) begin
                            cnt_nxt = '0;
                            if (run) begin
                                phase_nxt = PH_LOW;
                                fall_nxt  = 1'b1;
                            end else begin
                                phase_nxt = PH_IDLE;
                            end
                        end
                    end
                end
                default: begin
                    phase_nxt = PH_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // State, counter and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            rise_stb   <= 1'b0;
            fall_stb   <= 1'b0;
            mid_hi_stb <= 1'b0;
            mid_lo_stb <= 1'b0;
        end else begin
            phase      <= phase_nxt;
            cnt        <= cnt_nxt;
            rise_stb   <= rise_nxt;
            fall_stb   <= fall_nxt;
            mid_hi_stb <= mhi_nxt;
            mid_lo_stb <= mlo_nxt;
        end
    end

    // SCL is pulled low only during the low phase.
    assign scl_level = (phase != PH_LOW);

    // R6: a high phase with the line held low neither counts nor ends.
    a_r6_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_HIGH && !scl_sense) |=> (phase == PH_HIGH && $stable(cnt)));
    // R7: the edge strobes never coincide.
    a_r7_edge_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));
    // R7: a fall strobe follows a cycle with SCL released.
    a_r7_fall_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> ($past(scl_level) && !scl_level));
    // R8: the mid-low strobe occurs only while SCL is low or at the low-to-high edge.
    a_r8_mid_low_inside: assert property (@(posedge clk) disable iff (!rst_n)
        mid_lo_stb |-> (!scl_level || rise_stb));
    // R10: disabling returns to idle with SCL released.
    a_r10_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase == PH_IDLE && scl_level));
    // R1: without run the generator stays idle.
    a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !run) |=> (phase == PH_IDLE && !fall_stb));
endmodule

// File: rtl/scl_timing_gen.sv
// SCL clock timing generator top: field decode, prescaler, phase sequencer.
// Assumes the timing word is stable while the generator runs.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int CFG_W    = 32,
    parameter int BASE_W   = 4,
    parameter int CNT_W    = 4,
    parameter int BASE_LSB = 0,
    parameter int LO_LSB   = 12,
    parameter int HI_LSB   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [CFG_W-1:0] timing_cfg,
    input  logic             scl_sense,
    output logic             scl_level,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb,
    output logic             mid_high_stb,
    output logic             mid_low_stb
);
    logic [BASE_W-1:0] base;
    logic [CNT_W-1:0]  lo_cnt, hi_cnt;
    logic              tick, pre_restart;
    scl_phase_e        phase;

    scl_cfg_fields #(
        .CFG_W(CFG_W), .BASE_W(BASE_W), .CNT_W(CNT_W),
        .BASE_LSB(BASE_LSB), .LO_LSB(LO_LSB), .HI_LSB(HI_LSB)
    ) u_fields (
        .cfg(timing_cfg), .base(base), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
    );

    // Prescaler is held cleared while disabled or idle.
    assign pre_restart = !enable || (phase == PH_IDLE);

    scl_prescaler #(.BASE_W(BASE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(pre_restart), .base(base), .tick(tick)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .tick(tick),
        .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .scl_sense(scl_sense),
        .phase(phase), .scl_level(scl_level),
        .rise_stb(scl_rise_stb), .fall_stb(scl_fall_stb),
        .mid_hi_stb(mid_high_stb), .mid_lo_stb(mid_low_stb)
    );
endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic [31:0] cfg = '0;
    logic        force_low = 1'b0;
    logic        scl_level, rise_stb, fall_stb, mid_hi, mid_lo;
    wire         scl_sense = scl_level & ~force_low;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen i_scl_timing_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .timing_cfg(cfg), .scl_sense(scl_sense), .scl_level(scl_level),
        .scl_rise_stb(rise_stb), .scl_fall_stb(fall_stb),
        .mid_high_stb(mid_hi), .mid_low_stb(mid_lo)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int base, input int lo, input int hi);
        return {12'h000, hi[3:0], lo[3:0], 8'h00, base[3:0]};
    endfunction

    // Restart cleanly from idle with a new timing word and run asserted.
    task automatic start(input logic [31:0] w);
        @(negedge clk);
        enable = 1'b0; run = 1'b0; force_low = 1'b0;
        @(negedge clk);
        cfg = w; enable = 1'b1; run = 1'b1;
    endtask

    // Measure one period: low length, mid-low index, high length, mid-high index.
    // ext: number of edges with the line held low at the start of the high phase.
    task automatic measure(input int ext, output int lo_len, output int mlo,
                           output int hi_len, output int mhi);
        int idx;
        int guard;
        lo_len = -1; mlo = -1; hi_len = -1; mhi = -1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!fall_stb && guard < 5000);
        idx = 0;
        do begin
            @(negedge clk); idx++;
            if (mid_lo && mlo < 0) mlo = idx;
        end while (!rise_stb && idx < 5000);
        lo_len = idx;
        force_low = (ext > 0);
        idx = 0;
        do begin
            @(negedge clk); idx++;
            force_low = (idx < ext);
            if (mid_hi && mhi < 0) mhi = idx;
        end while (!fall_stb && idx < 5000);
        hi_len = idx;
        force_low = 1'b0;
    endtask

    task automatic t_reset_idle();
        int strobes;
        strobes = 0;
        enable = 1'b1; run = 1'b0; cfg = mk(0, 1, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rise_stb || fall_stb || mid_hi || mid_lo || !scl_level) strobes++;
        end
        chk("R1", "activity while idle", strobes, 0);
        chk("R1", "scl_level idle", int'(scl_level), 1);
    endtask

    task automatic t_period(input string req, input logic [31:0] w,
                            input int base, input int lo, input int hi);
        int l, ml, h, mh, t;
        t = 1 << base;
        start(w);
        measure(0, l, ml, h, mh);
        chk(req, "low length (R2)", l, (lo + 1) * t);
        chk(req, "high length (R3)", h, (hi + 1) * t);
        chk(req, "mid-low offset (R8)", ml, ((lo >> 1) + 1) * t);
        chk(req, "mid-high offset (R8)", mh, ((hi >> 1) + 1) * t);
    endtask

    task automatic t_unused_bits();
        logic [31:0] w;
        int l, ml, h, mh;
        w = mk(1, 2, 4) | 32'hFFF0_0FF0;
        start(w);
        measure(0, l, ml, h, mh);
        chk("R5", "low length with junk bits", l, 6);
        chk("R5", "high length with junk bits", h, 10);
        chk("R5", "mid-low with junk bits", ml, 4);
        chk("R5", "mid-high with junk bits", mh, 6);
    endtask

    task automatic t_stretch();
        int l, ml, h, mh;
        start(mk(0, 1, 3));
        measure(5, l, ml, h, mh);
        chk("R6", "stretched high length", h, 4 + 5);
        chk("R6", "stretched mid-high offset", mh, 5 + 2);
        chk("R6", "low length unaffected", l, 2);
    endtask

    task automatic t_run_drop();
        int idx, falls, rise_at, guard;
        start(mk(1, 2, 1));
        guard = 0;
        do begin @(negedge clk); guard++; end while (!fall_stb && guard < 100);
        run = 1'b0;
        idx = 0; falls = 0; rise_at = -1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); idx++;
            if (rise_stb && rise_at < 0) rise_at = idx;
            if (fall_stb) falls++;
        end
        chk("R9", "low phase completes after run drop", rise_at, 6);
        chk("R9", "no fall strobe after final high", falls, 0);
        chk("R9", "scl released at end", int'(scl_level), 1);
    endtask

    task automatic t_disable();
        int l, ml, h, mh, guard;
        int bad;
        start(mk(2, 1, 1));
        guard = 0;
        do begin @(negedge clk); guard++; end while (!fall_stb && guard < 100);
        @(negedge clk); @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R10", "scl released after disable", int'(scl_level), 1);
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (rise_stb || fall_stb || !scl_level) bad++;
        end
        chk("R10", "quiet while disabled", bad, 0);
        enable = 1'b1;
        measure(0, l, ml, h, mh);
        chk("R10", "exact low length after re-enable", l, 8);
        chk("R7", "high length after re-enable", h, 8);
    endtask

    task automatic t_strobe_width();
        int wide;
        start(mk(0, 0, 0));
        wide = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (fall_stb && scl_level) wide++;
            if (rise_stb && !scl_level) wide++;
        end
        chk("R7", "strobe aligned to phase", wide, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_period("R2", mk(0, 3, 5), 0, 3, 5);
        t_period("R3", mk(2, 1, 2), 2, 1, 2);
        t_period("R4", mk(0, 0, 0), 0, 0, 0);
        t_period("R4", mk(1, 0, 0), 1, 0, 0);
        t_period("R8", mk(0, 15, 15), 0, 15, 15);
        t_unused_bits();
        t_stretch();
        t_run_drop();
        t_disable();
        t_strobe_width();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule